// File: doc/BRIEF.md
# Interlocked Dual-Channel PWM Register Update

This block is a two-channel pulse width modulator in which software reprograms the waveforms through a small register bus. Each channel has its own free-running counter and three settings: period, duty and control. Every setting is held twice. A bus write lands in a shadow copy. The counter and the output only ever use the active copy.

Shadow values are copied into the active copies at a safe moment. By default that moment is the end of the channel's counting cycle. A per-channel immediate bit moves it to the clock after the copy is allowed. Two gating rules can hold the copy back, and both can be pending at the same time:

- **Data-then-control rule.** A duty write made through a channel's interlock address holds that channel's copy until its control register is also written.
- **Channel rule.** This rule applies only while both active periods are equal. The two channels are then treated as one unit. Writes to channel B hold the copy until the matching access to channel A has been made.

Top module: `pwm_ilk_top`

## Requirements
- R1: After a synchronous reset, all shadow and active settings, the immediate bits and every hold flag are zero. Both outputs are low and every readable address returns zero.
- R2: The channel counter runs 0,1,...,P and wraps to 0, where P is the active period. Control bit 0 enables the output, which is then high while the count is below the active duty. Control bit 1 inverts the output.
- R3: With the immediate bit clear and no hold pending, the shadow settings become active on the clock edge at which the channel's counter wraps. Address map: 0 = A duty direct, 1 = A duty interlock, 2 = A control, 3 = A period. Addresses 4 to 7 are the same for B. Address 8 is the immediate register.
- R4: In the immediate register, bit 0 belongs to channel A and bit 1 to channel B. When a channel's bit is set, its shadow settings become active one clock after the last hold on that channel is released, without waiting for a wrap.
- R5: A write to a channel's interlock duty address holds that channel's transfer until that channel's control register is written. A write to the direct duty address creates no such hold.
- R6: While the active periods are equal, a write to either B duty address holds both channels until a read or a write at either A duty address.
- R7: While the active periods are equal, a write to the B control register holds both channels until the A control register is written.
- R8: A write to the A interlock duty address releases the hold from R6, but it places the R5 hold on channel A. An A control write is then needed before anything transfers.
- R9: While the active periods differ, the R6 and R7 holds are neither created nor kept, and each channel transfers on its own wrap.
- R10: While the active periods are equal, both channels transfer on channel A's wrap. Channel A's wrap also restarts channel B's counter, which puts the two waveforms in phase.
- R11: The read data returns the shadow value at the selected address: duty at both duty addresses, control in bits 1:0, and the immediate register in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (counts as an access for R6) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the shadow copies |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |

## Verification
The hardest state to reach is the overlap of the two gating rules while the periods are linked. In that state a B duty write is pending, and an A interlock write then swaps that hold for a data-then-control hold on A. The stimulus first equalises the periods through a non-immediate period write. It then waits past a wrap so that the link is active, and only then issues the B write, the A interlock write and the late A control write. Long idle stretches between these steps show that nothing transfers early. A second pass repeats the gating with the immediate bits set and the periods unlinked, which separates the immediate path from the wrap path.

// File: rtl/pwm_ilk_pkg.sv
package pwm_ilk_pkg;
    localparam int unsigned PW     = 8;   // data, duty, period and counter width
    localparam int unsigned AW     = 4;   // register address width
    localparam int unsigned NCH    = 2;   // number of channels
    localparam int unsigned FLDS   = 4;   // addresses per channel
    localparam int unsigned CH_LEAD   = 0;  // channel A
    localparam int unsigned CH_FOLLOW = 1;  // channel B

    localparam int unsigned F_DAT  = 0;
    localparam int unsigned F_ILK  = 1;
    localparam int unsigned F_CTL  = 2;
    localparam int unsigned F_RATE = 3;

    localparam logic [AW-1:0] ADDR_UPD = AW'(NCH * FLDS);

    typedef logic [PW-1:0] word_t;

    typedef struct packed {
        logic inv;
        logic en;
    } ctl_t;

    typedef struct packed {
        word_t duty;
        ctl_t  ctl;
        word_t rate;
    } chset_t;

    function automatic logic [AW-1:0] reg_addr(input int unsigned ch, input int unsigned fld);
        return AW'(ch * FLDS + fld);
    endfunction
endpackage

// File: rtl/pwm_ilk_chan.sv
module pwm_ilk_chan
    import pwm_ilk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  chset_t nxt,
    input  logic   realign,
    output chset_t act,
    output logic   wrap,
    output logic   pwm
);
    word_t  cnt;
    chset_t act_q;

    assign act  = act_q;
    assign wrap = (cnt >= act_q.rate);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            act_q <= '0;
        end else begin
            if (wrap || realign) cnt <= '0;
            else                 cnt <= cnt + 1'b1;
            if (load) act_q <= nxt;
        end
    end

    assign pwm = (act_q.ctl.en && (cnt < act_q.duty)) ^ act_q.ctl.inv;
endmodule

// File: rtl/pwm_ilk_regs.sv
module pwm_ilk_regs
    import pwm_ilk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       addr,
    input  logic                wr,
    input  logic                rd,
    input  word_t               wdata,
    input  logic [NCH-1:0]      wrap,
    input  logic                linked,
    output chset_t [NCH-1:0]    shadow,
    output logic [NCH-1:0]      load,
    output word_t               rdata,
    output logic [NCH-1:0]      dc_need,
    output logic                ab_dat,
    output logic                ab_ctl,
    output logic [NCH-1:0]      upd
);
    logic [NCH-1:0] wr_dat, wr_ilk, wr_ctl, wr_rate, blocked, evt;
    logic           hold_all, lead_dat_acc;

    assign hold_all = (|dc_need) || ab_dat || ab_ctl;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chset_t sh_q;
        logic   dc_q;

        assign wr_dat[c]  = wr && (addr == reg_addr(c, F_DAT));
        assign wr_ilk[c]  = wr && (addr == reg_addr(c, F_ILK));
        assign wr_ctl[c]  = wr && (addr == reg_addr(c, F_CTL));
        assign wr_rate[c] = wr && (addr == reg_addr(c, F_RATE));

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q <= '0;
                dc_q <= 1'b0;
            end else begin
                if (wr_dat[c] || wr_ilk[c]) sh_q.duty <= wdata;
                if (wr_ctl[c])              sh_q.ctl  <= ctl_t'(wdata[1:0]);
                if (wr_rate[c])             sh_q.rate <= wdata;
                if (wr_ilk[c])      dc_q <= 1'b1;
                else if (wr_ctl[c]) dc_q <= 1'b0;
            end
        end

        assign shadow[c]  = sh_q;
        assign dc_need[c] = dc_q;
        assign blocked[c] = linked ? hold_all : dc_q;
        assign evt[c]     = linked ? wrap[CH_LEAD] : wrap[c];
        assign load[c]    = !blocked[c] && (evt[c] || upd[c]);
    end

    assign lead_dat_acc = (wr || rd) &&
                          ((addr == reg_addr(CH_LEAD, F_DAT)) || (addr == reg_addr(CH_LEAD, F_ILK)));

    always_ff @(posedge clk) begin
        if (rst || !linked) begin
            ab_dat <= 1'b0;
            ab_ctl <= 1'b0;
        end else begin
            if (lead_dat_acc)                                   ab_dat <= 1'b0;
            else if (wr_dat[CH_FOLLOW] || wr_ilk[CH_FOLLOW])    ab_dat <= 1'b1;
            if (wr_ctl[CH_LEAD])        ab_ctl <= 1'b0;
            else if (wr_ctl[CH_FOLLOW]) ab_ctl <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                           upd <= '0;
        else if (wr && addr == ADDR_UPD)   upd <= wdata[NCH-1:0];
    end

    always_comb begin
        rdata = '0;
        for (int unsigned c = 0; c < NCH; c++) begin
            if (addr == reg_addr(c, F_DAT) || addr == reg_addr(c, F_ILK)) rdata = shadow[c].duty;
            if (addr == reg_addr(c, F_CTL))  rdata = word_t'(shadow[c].ctl);
            if (addr == reg_addr(c, F_RATE)) rdata = shadow[c].rate;
        end
        if (addr == ADDR_UPD) rdata = word_t'(upd);
    end
endmodule

// File: rtl/pwm_ilk_top.sv
module pwm_ilk_top
    import pwm_ilk_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [PW-1:0] bus_wdata,
    output logic [PW-1:0] bus_rdata,
    output logic          pwm_a,
    output logic          pwm_b
);
    chset_t [NCH-1:0] shadow;
    chset_t [NCH-1:0] act;
    logic   [NCH-1:0] load, wrap, pwm, dc_need, upd, realign;
    logic             ab_dat, ab_ctl, linked;

    assign linked = (act[CH_LEAD].rate == act[CH_FOLLOW].rate);

    pwm_ilk_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .wrap    (wrap),
        .linked  (linked),
        .shadow  (shadow),
        .load    (load),
        .rdata   (bus_rdata),
        .dc_need (dc_need),
        .ab_dat  (ab_dat),
        .ab_ctl  (ab_ctl),
        .upd     (upd)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        if (c == CH_LEAD) begin : g_lead
            assign realign[c] = 1'b0;
        end else begin : g_follow
            assign realign[c] = linked && wrap[CH_LEAD];
        end

        pwm_ilk_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .load    (load[c]),
            .nxt     (shadow[c]),
            .realign (realign[c]),
            .act     (act[c]),
            .wrap    (wrap[c]),
            .pwm     (pwm[c])
        );
    end

    assign pwm_a = pwm[CH_LEAD];
    assign pwm_b = pwm[CH_FOLLOW];
endmodule

// File: rtl/pwm_ilk_chk.sv
module pwm_ilk_chk
    import pwm_ilk_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [1:0]     pwm,
    input logic           wrap_a,
    input logic [NCH-1:0] dc,
    input logic           ab_dat,
    input logic           ab_ctl,
    input logic           linked,
    input logic           upd_a,
    input chset_t         act_a,
    input chset_t         act_b
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pwm == 2'b00 && dc == '0 && !ab_dat && !ab_ctl));

    assert_wait_for_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (!upd_a && !wrap_a) |=> $stable(act_a));

    assert_data_ctl_hold_a_R5: assert property (@(posedge clk) disable iff (rst)
        dc[0] |=> $stable(act_a));

    assert_data_ctl_hold_b_R5: assert property (@(posedge clk) disable iff (rst)
        (dc[1] && !linked) |=> $stable(act_b));

    assert_chan_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (linked && ab_dat) |=> ($stable(act_a) && $stable(act_b)));

    assert_chan_ctl_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (linked && ab_ctl) |=> ($stable(act_a) && $stable(act_b)));

    assert_unlinked_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (!linked && !$past(linked)) |-> (!ab_dat && !ab_ctl));
endmodule

bind pwm_ilk_top pwm_ilk_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pwm    ({pwm_b, pwm_a}),
    .wrap_a (wrap[0]),
    .dc     (dc_need),
    .ab_dat (ab_dat),
    .ab_ctl (ab_ctl),
    .linked (linked),
    .upd_a  (upd[0]),
    .act_a  (act[0]),
    .act_b  (act[1])
);

// File: tb/pwm_ilk_top_bench.sv
module pwm_ilk_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = 4'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       pwm_a, pwm_b;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;  // 125 MHz

    pwm_ilk_top u_pwm_ilk_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    // ---------------- behavioural reference model ----------------
    int m_cnt[2], m_duty[2], m_ctl[2], m_rate[2];
    int s_duty[2], s_ctl[2], s_rate[2], m_upd[2], m_dc[2];
    int m_abd, m_abc;

    always @(posedge clk) begin
        bit lk, hold, blk, ev;
        bit wr_[2];
        bit ld[2];
        int a;
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_cnt[c] = 0; m_duty[c] = 0; m_ctl[c] = 0; m_rate[c] = 0;
                s_duty[c] = 0; s_ctl[c] = 0; s_rate[c] = 0; m_upd[c] = 0; m_dc[c] = 0;
            end
            m_abd = 0; m_abc = 0;
        end else begin
            lk   = (m_rate[0] == m_rate[1]);
            hold = (m_dc[0] != 0) || (m_dc[1] != 0) || (m_abd != 0) || (m_abc != 0);
            for (int c = 0; c < 2; c++) wr_[c] = (m_cnt[c] >= m_rate[c]);
            for (int c = 0; c < 2; c++) begin
                blk   = lk ? hold : (m_dc[c] != 0);
                ev    = lk ? wr_[0] : wr_[c];
                ld[c] = !blk && (ev || m_upd[c] != 0);
            end
            m_cnt[0] = wr_[0] ? 0 : m_cnt[0] + 1;
            m_cnt[1] = (wr_[1] || (lk && wr_[0])) ? 0 : m_cnt[1] + 1;
            for (int c = 0; c < 2; c++) if (ld[c]) begin
                m_duty[c] = s_duty[c]; m_ctl[c] = s_ctl[c]; m_rate[c] = s_rate[c];
            end
            a = int'(bus_addr);
            if (bus_wr) begin
                if (a < 8) begin
                    if (a % 4 <= 1) s_duty[a / 4] = int'(bus_wdata);
                    if (a % 4 == 2) s_ctl[a / 4]  = int'(bus_wdata) % 4;
                    if (a % 4 == 3) s_rate[a / 4] = int'(bus_wdata);
                    if (a % 4 == 1) m_dc[a / 4] = 1;
                    if (a % 4 == 2) m_dc[a / 4] = 0;
                end
                if (a == 8) begin
                    m_upd[0] = int'(bus_wdata[0]); m_upd[1] = int'(bus_wdata[1]);
                end
            end
            if (!lk) begin
                m_abd = 0; m_abc = 0;
            end else begin
                if ((bus_wr || bus_rd) && a <= 1) m_abd = 0;
                else if (bus_wr && (a == 4 || a == 5)) m_abd = 1;
                if (bus_wr && a == 2) m_abc = 0;
                else if (bus_wr && a == 6) m_abc = 1;
            end
        end
    end

    function automatic bit exp_pwm(int c);
        return ((m_ctl[c] % 2 == 1) && (m_cnt[c] < m_duty[c])) ^ (m_ctl[c] / 2 == 1);
    endfunction

    function automatic int exp_rdata(int a);
        if (a < 8) begin
            if (a % 4 <= 1) return s_duty[a / 4];
            if (a % 4 == 2) return s_ctl[a / 4];
            return s_rate[a / 4];
        end
        if (a == 8) return m_upd[0] + 2 * m_upd[1];
        return 0;
    endfunction

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from both edges
    always begin
        @(posedge clk);
        #2;
        if (!rst && !done) begin
            chk(int'(pwm_a), int'(exp_pwm(0)), cur_req, "pwm_a vs model");
            chk(int'(pwm_b), int'(exp_pwm(1)), cur_req, "pwm_b vs model");
            chk(int'(bus_rdata), exp_rdata(int'(bus_addr)), "R11", "rdata vs model");
        end
    end

    task automatic put(input int a, input int d);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic get(input int a);
        @(negedge clk);
        bus_addr = 4'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int ha, output int hb, output int bnota);
        ha = 0; hb = 0; bnota = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            if (pwm_a) ha++;
            if (pwm_b) hb++;
            if (pwm_b && !pwm_a) bnota++;
        end
    endtask

    initial begin
        int ha, hb, bn;
        idle(3);
        @(negedge clk); rst = 1'b0;
        // R1: reset state at the ports
        for (int a = 0; a <= 8; a++) begin
            bus_addr = 4'(a); #1;
            chk(int'(bus_rdata), 0, "R1", "rdata after reset");
        end
        chk(int'({pwm_b, pwm_a}), 0, "R1", "outputs after reset");
        bus_addr = 4'd0;

        // R2 / R4: immediate load on A, then measure the duty
        cur_req = "R4";
        put(8, 1); put(3, 9); put(0, 3); put(2, 1);
        idle(20);
        cur_req = "R2";
        count_high(10, ha, hb, bn);
        chk(ha, 3, "R2", "A high count, duty 3 period 10");
        put(2, 3);
        idle(20);
        count_high(10, ha, hb, bn);
        chk(ha, 7, "R2", "A high count inverted");

        // R3: wrap-timed loading, immediate bits clear
        cur_req = "R3";
        put(8, 0); put(7, 4); put(4, 2); put(6, 1);
        idle(15);
        put(0, 5);
        idle(25);
        count_high(10, ha, hb, bn);
        chk(ha, 5, "R3", "A inverted high count after duty 5 at wrap");

        // R5: interlock duty write waits for control
        cur_req = "R5";
        put(1, 6);
        idle(30);
        count_high(10, ha, hb, bn);
        chk(ha, 5, "R5", "A unchanged while data-control hold pending");
        put(2, 1);
        idle(25);
        count_high(10, ha, hb, bn);
        chk(ha, 6, "R5", "A after control write releases hold");

        // R10: equal periods link the channels and align them
        cur_req = "R10";
        put(7, 9);
        idle(40);
        count_high(20, ha, hb, bn);
        chk(bn, 0, "R10", "B high while A low after alignment");
        chk(hb, 4, "R10", "B high count duty 2 over 20");

        // R6: B data waits for an A data access
        cur_req = "R6";
        put(4, 7);
        idle(30);
        count_high(10, ha, hb, bn);
        chk(hb, 2, "R6", "B held before A access");
        get(0);
        idle(25);
        count_high(10, ha, hb, bn);
        chk(hb, 7, "R6", "B after A read");

        // R7: B control waits for A control
        cur_req = "R7";
        put(6, 3);
        idle(30);
        count_high(10, ha, hb, bn);
        chk(hb, 7, "R7", "B control held");
        put(2, 1);
        idle(25);
        count_high(10, ha, hb, bn);
        chk(hb, 3, "R7", "B inverted after A control write");

        // R8: A interlock access swaps hold
        cur_req = "R8";
        put(4, 1); put(1, 4);
        idle(30);
        count_high(10, ha, hb, bn);
        chk(ha, 6, "R8", "A held by its own data-control hold");
        chk(hb, 3, "R8", "B held by A data-control hold");
        put(2, 1);
        idle(25);
        count_high(10, ha, hb, bn);
        chk(ha, 4, "R8", "A after control write");
        chk(hb, 9, "R8", "B after control write");

        // R9: different periods, no channel hold
        cur_req = "R9";
        put(3, 12);
        idle(30);
        put(4, 5);
        idle(30);
        count_high(10, ha, hb, bn);
        chk(hb, 5, "R9", "B loads without A access");

        // R4: immediate with a data-control hold pending
        cur_req = "R4";
        put(8, 3); put(1, 2);
        idle(20);
        count_high(13, ha, hb, bn);
        chk(ha, 4, "R4", "A still held with immediate bit set");
        put(2, 1);
        idle(20);
        count_high(13, ha, hb, bn);
        chk(ha, 2, "R4", "A after release with immediate bit");
        put(8, 0);
        idle(5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule